// File: doc/BRIEF.md
# Line Coefficient Memory Controller

This block drives an external per-pixel coefficient memory across one scan line of an image scanner front end. A single address counter walks the line one word per pixel. The input clock runs at twice the pixel rate, so every pixel is split into two clock phases. On a training line the block writes a fresh coefficient into each word. The coefficient is looked up from the digitised white-reference level. On a correction line it reads the stored coefficients back for the downstream multiplier.

Training is requested by a low pulse on `train_n` and applies to the next line that starts. With a read-only memory fitted (`rom_mode` high), the block never drives the data bus and never writes, so the stored coefficients stay fixed. A `run` input pauses the line in the middle of a scan. The line then resumes at the same pixel and phase. The block does not include analog conversion or the multiply datapath.

Top module: `lcm_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `mem_oe`, `mem_wr`, `coef_drv`, `pix_stb` and `out_valid` are 0 and `mem_addr` is 0.
- R2: A line is active from the cycle after `line_en` is first sampled high until the cycle after it is sampled low. The line starts with `mem_addr` 0 in phase 0. Each phase-1 cycle with `run` high advances `mem_addr` by one. When the line is not active, `mem_addr` is 0.
- R3: `pix_stb` is high exactly in phase-1 cycles of an active, unfinished line while `run` is high. Each pixel therefore takes two clock cycles.
- R4: Sampling `train_n` low arms training. The next line start turns that line into a training line when `rom_mode` is 0 at the start, and it clears the arm. A pulse during an active line has no effect on that line.
- R5: On a training line, `mem_oe` is 0 and `coef_drv` is 1 in both phases. `mem_wr` is 1 in phase 1 while `run` is high.
- R6: On a correction line, `mem_oe` is 1 in phase 0 and `mem_wr` and `coef_drv` are 0. If `run` is high in a phase-0 cycle, `coef_rd` takes `coef_in` at the end of that cycle and `out_valid` is 1 in the next cycle. Otherwise `out_valid` is 0.
- R7: While `run` is low, the address and phase do not change, `pix_stb` and `mem_wr` are 0, and `coef_rd` holds its value.
- R8: While `rom_mode` is 1, `mem_wr` is 0. A line that starts with `rom_mode` at 1 never asserts `coef_drv`.
- R9: After the pixel at address 4095 completes, `mem_oe`, `mem_wr`, `coef_drv` and `pix_stb` stay 0 and `mem_addr` stays 4095 until the line ends.
- R10: `coef_out` is the lookup of the `white_code` sampled one cycle earlier:
  - for w < 4, the value is 7Fh;
  - otherwise, the value is min(7Fh, floor((8128 + floor(w/2)) / w)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double pixel-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_en | input | 1 | High across the active pixels of a line |
| train_n | input | 1 | Low pulse arms a white-reference training line |
| run | input | 1 | High runs the scan, low pauses it in place |
| rom_mode | input | 1 | High when the coefficient memory is read-only |
| white_code | input | 7 | Digitised white-reference level |
| coef_in | input | 7 | Coefficient read from memory |
| mem_addr | output | 12 | Pixel address to memory |
| mem_oe | output | 1 | Memory output enable |
| mem_wr | output | 1 | Memory write strobe |
| coef_out | output | 7 | Coefficient to write |
| coef_drv | output | 1 | Enables the block's drive of the data bus |
| pix_stb | output | 1 | Pixel-rate strobe |
| coef_rd | output | 7 | Last coefficient read |
| out_valid | output | 1 | Pixel data valid |

## Verification
The bench stores writes in a memory model, so that a training line followed by a correction line checks the written coefficients end to end. Pauses land on both phases. A design that kept toggling phase during a pause would skip or repeat addresses. A design that wrote during a pause would corrupt a word.

A training pulse is given in the middle of a line. A design that applied it at once would start writing mid-line. A run past 4096 pixels catches a counter that wraps to zero and overwrites the first word. Read-only mode with training armed catches any write or bus drive. The `white_code` sweep covers the saturated codes, the zero divisor and the rounding at the top of the range.

// File: rtl/lcm_pkg.sv
package lcm_pkg;
    // Reciprocal gain: round(k / w), saturated, with tiny w forced to max.
    function automatic int recip_gain(input int w, input int k,
                                      input int min_code, input int max_val);
        int q;
        if (w < min_code) return max_val;
        q = (k + w / 2) / w;
        if (q > max_val) q = max_val;
        return q;
    endfunction
endpackage

// File: rtl/lcm_coef_lut.sv
module lcm_coef_lut #(
    parameter int CW       = 7,
    parameter int GAIN_K   = 8128,
    parameter int MIN_CODE = 4
) (
    input  logic [CW-1:0] code_i,
    output logic [CW-1:0] coef_o
);
    localparam int NUM  = 2 ** CW;
    localparam int MAXV = NUM - 1;

    logic [CW-1:0] tbl [NUM];

    for (genvar g = 0; g < NUM; g++) begin : g_ent
        assign tbl[g] = CW'(lcm_pkg::recip_gain(g, GAIN_K, MIN_CODE, MAXV));
    end

    assign coef_o = tbl[code_i];
endmodule

// File: rtl/lcm_seq.sv
module lcm_seq #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_en,
    input  logic          run,
    input  logic          train_n,
    input  logic          rom_mode,
    output logic          en_o,
    output logic          phase_o,
    output logic          full_o,
    output logic          train_o,
    output logic [AW-1:0] addr_o
);
    localparam logic [AW-1:0] LAST = {AW{1'b1}};

    typedef struct packed {
        logic          en;
        logic          ph;
        logic          full;
        logic          train;
        logic          arm;
        logic [AW-1:0] addr;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.en = line_en;
        if (!line_en) begin
            s_d.ph    = 1'b0;
            s_d.full  = 1'b0;
            s_d.train = 1'b0;
            s_d.addr  = '0;
            s_d.arm   = s_q.arm | ~train_n;
        end else if (!s_q.en) begin
            s_d.ph    = 1'b0;
            s_d.full  = 1'b0;
            s_d.addr  = '0;
            s_d.train = (s_q.arm | ~train_n) & ~rom_mode;
            s_d.arm   = 1'b0;
        end else begin
            s_d.arm = s_q.arm | ~train_n;
            if (run && !s_q.full) begin
                if (s_q.ph) begin
                    s_d.ph = 1'b0;
                    if (s_q.addr == LAST) s_d.full = 1'b1;
                    else                  s_d.addr = s_q.addr + 1'b1;
                end else begin
                    s_d.ph = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign en_o    = s_q.en;
    assign phase_o = s_q.ph;
    assign full_o  = s_q.full;
    assign train_o = s_q.train;
    assign addr_o  = s_q.addr;
endmodule

// File: rtl/lcm_ctrl.sv
module lcm_ctrl #(
    parameter int AW       = 12,
    parameter int CW       = 7,
    parameter int GAIN_K   = 8128,
    parameter int MIN_CODE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_en,
    input  logic          train_n,
    input  logic          run,
    input  logic          rom_mode,
    input  logic [CW-1:0] white_code,
    input  logic [CW-1:0] coef_in,
    output logic [AW-1:0] mem_addr,
    output logic          mem_oe,
    output logic          mem_wr,
    output logic [CW-1:0] coef_out,
    output logic          coef_drv,
    output logic          pix_stb,
    output logic [CW-1:0] coef_rd,
    output logic          out_valid
);
    typedef struct packed {
        logic [CW-1:0] wcoef;
        logic [CW-1:0] rd;
        logic          vld;
    } dp_t;

    logic          en, ph, full, train, act, rd_now;
    logic [CW-1:0] lut_coef;
    dp_t           d_d, d_q;

    lcm_seq #(.AW(AW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_en  (line_en),
        .run      (run),
        .train_n  (train_n),
        .rom_mode (rom_mode),
        .en_o     (en),
        .phase_o  (ph),
        .full_o   (full),
        .train_o  (train),
        .addr_o   (mem_addr)
    );

    lcm_coef_lut #(.CW(CW), .GAIN_K(GAIN_K), .MIN_CODE(MIN_CODE)) u_lut (
        .code_i (white_code),
        .coef_o (lut_coef)
    );

    assign act    = en & ~full;
    assign rd_now = act & ~train & ~ph & run;

    always_comb begin
        d_d       = d_q;
        d_d.wcoef = lut_coef;
        d_d.vld   = rd_now;
        if (rd_now) d_d.rd = coef_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign mem_oe    = act & ~train & ~ph;
    assign mem_wr    = act & train & ph & run & ~rom_mode;
    assign coef_drv  = act & train & ~rom_mode;
    assign pix_stb   = act & ph & run;
    assign coef_out  = d_q.wcoef;
    assign coef_rd   = d_q.rd;
    assign out_valid = d_q.vld;
endmodule

// File: rtl/lcm_ctrl_chk.sv
module lcm_ctrl_chk #(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          line_en,
    input logic          run,
    input logic          rom_mode,
    input logic [AW-1:0] mem_addr,
    input logic          mem_oe,
    input logic          mem_wr,
    input logic          pix_stb,
    input logic          out_valid
);
    localparam logic [AW-1:0] LAST = {AW{1'b1}};

    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_stb && line_en && mem_addr != LAST) |=> (mem_addr == $past(mem_addr) + 1'b1));

    p_stb_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_stb |=> !pix_stb);

    p_wr_not_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> !mem_oe);

    p_valid_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(mem_oe));

    p_hold_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && line_en) |=> $stable(mem_addr));

    p_rom_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rom_mode |-> !mem_wr);
endmodule

bind lcm_ctrl lcm_ctrl_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_en   (line_en),
    .run       (run),
    .rom_mode  (rom_mode),
    .mem_addr  (mem_addr),
    .mem_oe    (mem_oe),
    .mem_wr    (mem_wr),
    .pix_stb   (pix_stb),
    .out_valid (out_valid)
);

// File: tb/tb_lcm_ctrl.sv
`timescale 1ns/1ps
module tb_lcm_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_en = 1'b0, train_n = 1'b1, run = 1'b1, rom_mode = 1'b0;
    logic [6:0] white_code = '0;
    logic [6:0] coef_in;
    logic [11:0] mem_addr;
    logic       mem_oe, mem_wr, coef_drv, pix_stb, out_valid;
    logic [6:0] coef_out, coef_rd;

    int total = 0, bad = 0;
    bit finished = 0;
    int lfsr = 32'h1ACE5;
    logic [6:0] mem [4096];

    always #4 clk = ~clk;

    lcm_ctrl dut (
        .clk(clk), .rst_n(rst_n), .line_en(line_en), .train_n(train_n),
        .run(run), .rom_mode(rom_mode), .white_code(white_code),
        .coef_in(coef_in), .mem_addr(mem_addr), .mem_oe(mem_oe),
        .mem_wr(mem_wr), .coef_out(coef_out), .coef_drv(coef_drv),
        .pix_stb(pix_stb), .coef_rd(coef_rd), .out_valid(out_valid)
    );

    // external memory model
    assign coef_in = mem[mem_addr];
    initial for (int i = 0; i < 4096; i++) mem[i] = 7'((i * 13 + 5) & 127);
    always @(posedge clk) if (mem_wr) mem[mem_addr] <= coef_out;

    // behavioural reference model
    int m_en = 0, m_ph = 0, m_addr = 0, m_full = 0, m_train = 0, m_arm = 0;
    int m_coef = 0, m_rd = 0, m_vld = 0;

    function automatic int ref_coef(int w);
        int q;
        if (w < 4) return 127;
        q = (8128 + w / 2) / w;
        return (q > 127) ? 127 : q;
    endfunction

    always @(posedge clk) begin
        int act;
        act = m_en && !m_full;
        if (!rst_n) begin
            m_en <= 0; m_ph <= 0; m_addr <= 0; m_full <= 0; m_train <= 0;
            m_arm <= 0; m_coef <= 0; m_rd <= 0; m_vld <= 0;
        end else begin
            m_coef <= ref_coef(int'(white_code));
            m_vld  <= (act && !m_train && m_ph == 0 && run) ? 1 : 0;
            if (act && !m_train && m_ph == 0 && run) m_rd <= int'(coef_in);
            m_en <= line_en ? 1 : 0;
            if (!line_en) begin
                m_ph <= 0; m_full <= 0; m_train <= 0; m_addr <= 0;
                if (!train_n) m_arm <= 1;
            end else if (m_en == 0) begin
                m_ph <= 0; m_full <= 0; m_addr <= 0;
                m_train <= ((m_arm || !train_n) && !rom_mode) ? 1 : 0;
                m_arm <= 0;
            end else begin
                if (!train_n) m_arm <= 1;
                if (run && !m_full) begin
                    if (m_ph == 1) begin
                        m_ph <= 0;
                        if (m_addr == 4095) m_full <= 1;
                        else m_addr <= m_addr + 1;
                    end else m_ph <= 1;
                end
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    task automatic compare();
        int a;
        a = (m_en && !m_full) ? 1 : 0;
        chk("R2 mem_addr", int'(mem_addr), m_addr);
        chk("R3/R7/R9 pix_stb", int'(pix_stb), (a && m_ph == 1 && run) ? 1 : 0);
        chk("R6/R9 mem_oe", int'(mem_oe), (a && !m_train && m_ph == 0) ? 1 : 0);
        chk("R5/R7/R8 mem_wr", int'(mem_wr),
            (a && m_train && m_ph == 1 && run && !rom_mode) ? 1 : 0);
        chk("R4/R5/R8 coef_drv", int'(coef_drv), (a && m_train && !rom_mode) ? 1 : 0);
        chk("R10 coef_out", int'(coef_out), m_coef);
        chk("R6/R7 coef_rd", int'(coef_rd), m_rd);
        chk("R6 out_valid", int'(out_valid), m_vld);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic rnd();
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h80200003 : 0);
    endtask

    // one line of ncyc cycles; holds when with_hold
    task automatic do_line(int ncyc, bit with_hold, int pulse_at);
        line_en = 1'b1;
        for (int k = 0; k < ncyc; k++) begin
            rnd();
            run        = with_hold ? ((lfsr & 3) != 0) : 1'b1;
            white_code = 7'(lfsr >> 4);
            train_n    = (k == pulse_at) ? 1'b0 : 1'b1;
            tick();
        end
        train_n = 1'b1;
        run     = 1'b1;
        line_en = 1'b0;
        repeat (3) tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (2) tick();
        // R1 reset state
        chk("R1 reset mem_oe", int'(mem_oe), 0);
        chk("R1 reset pix_stb", int'(pix_stb), 0);
        chk("R1 reset mem_addr", int'(mem_addr), 0);
        rst_n = 1'b1;
        tick();
        chk("R1 after release out_valid", int'(out_valid), 0);
        chk("R1 after release coef_drv", int'(coef_drv), 0);

        // correction line reading preset contents
        do_line(40, 0, -1);
        // arm, then training line with pauses
        train_n = 1'b0; tick(); train_n = 1'b1; tick();
        do_line(60, 1, -1);
        // correction line reading trained words back, with pauses
        do_line(70, 1, -1);
        // read-only memory with training armed: no write, no drive (R8)
        rom_mode = 1'b1;
        train_n = 1'b0; tick(); train_n = 1'b1;
        do_line(30, 1, -1);
        rom_mode = 1'b0;
        // pulse mid-line only affects the following line (R4)
        do_line(20, 0, 7);
        do_line(24, 1, -1);
        do_line(20, 0, -1);
        // full-length line past the last address (R9)
        line_en = 1'b1; run = 1'b1;
        for (int k = 0; k < 8192 + 20; k++) begin
            rnd();
            white_code = 7'(lfsr >> 3);
            tick();
        end
        chk("R9 end mem_oe", int'(mem_oe), 0);
        chk("R9 end pix_stb", int'(pix_stb), 0);
        chk("R9 end mem_addr", int'(mem_addr), 4095);
        line_en = 1'b0; repeat (3) tick();
        // lookup sweep (R10)
        for (int w = 0; w < 128; w++) begin
            white_code = 7'(w);
            tick();
        end
        white_code = 7'd3; tick();
        chk("R10 code 3", int'(coef_out), 127);
        white_code = 7'd127; tick();
        chk("R10 code 127", int'(coef_out), 64);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule